// File: doc/BRIEF.md
# Bit-level I2C master engine

This block is a single-master I2C bit engine that turns host commands into bus activity on two open-drain lines. The host issues one command at a time: generate a START condition, generate a STOP condition, shift a byte out and collect the slave's acknowledge, shift a byte in and answer it with a host-chosen acknowledge level, or wipe the error register. Every bus phase is timed in whole microseconds, derived from a parameter giving the number of system clocks per microsecond. The schedule is conservative enough to stay at or below 100 kHz.

Whenever the engine lets a line float high, it reads the line back through a synchronizer at a fixed point in the schedule. A line found low at that point yields a numbered error code. Only the first such code is kept, and it stays until the host clears it, so a host can run a whole transfer and inspect a single code at the end. Clock stretching, multi-master arbitration and multi-byte scripting are left to the host.

Top module: `i2c_bit_master`

## Requirements
- R1: After reset, `scl_o` and `sda_o` are 1 (both lines released), `busy` and `done` are 0 and `err_code` is 0.
- R2: Command code 0 (START) ends with a falling SDA while SCL is high, and leaves both outputs at 0. Command code 1 (STOP) ends with a rising SDA while SCL is high, and leaves both outputs at 1.
- R3: Command code 2 (WRITE) sends `cmd_wdata` most significant bit first as 8 clock pulses. It then releases SDA for a ninth pulse and reports the level it sampled there on `slave_ack` (0 = acknowledged).
- R4: A WRITE whose ninth-pulse sample is 1 (not acknowledged) sets `slave_ack` to 1 and reports error code 3.
- R5: Command code 3 (READ) samples 8 bits during SCL-high, most significant first, and presents them on `rd_data` at `done`. On a ninth pulse it drives SDA to the `cmd_ack` level (0 = acknowledge, 1 = not acknowledge).
- R6: If SCL reads low 3 us after the engine released it, error code 1 is reported.
- R7: If SDA reads low 3 us after the engine released it to send a 1 data bit, error code 2 is reported.
- R8: If SDA reads low 3 us after the engine released it at the end of STOP, error code 4 is reported.
- R9: `err_code` keeps the first nonzero code reported and ignores later ones. Command code 4 (CLEAR) sets it back to 0.
- R10: `busy` is high from the cycle after a command is accepted until the command ends. `done` is a one-cycle pulse in the first cycle with `busy` low again. Commands are accepted only while `busy` is low.
- R11: SCL stays high for 9 us on each bit the engine sends and for 6 us on each bit it receives. `scl_o` and `sda_o` never change in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when `busy` is low |
| cmd_op | input | 3 | 0 START, 1 STOP, 2 WRITE, 3 READ, 4 CLEAR; other codes are not taken |
| cmd_wdata | input | 8 | Byte to send for WRITE |
| cmd_ack | input | 1 | Acknowledge level sent after a READ |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rd_data | output | 8 | Byte received by the last READ |
| slave_ack | output | 1 | Ninth-bit level sampled by the last WRITE |
| err_code | output | 3 | Sticky first error code, 0 when clean |
| scl_o | output | 1 | SCL open-drain control: 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA open-drain control: 0 pulls low, 1 releases |
| scl_i | input | 1 | SCL line level as seen on the bus |
| sda_i | input | 1 | SDA line level as seen on the bus |

## Verification
The bench places a behavioural slave on the wired-AND lines and holds a line low on purpose to provoke each error code. It then issues later faults while an earlier code is still set: a register that overwrites would show the newer code instead of the first one. A byte sent or captured least significant bit first would show up as a reversed pattern at the slave or on `rd_data`. It also measures every SCL high period of a byte transfer, because an off-by-one in the microsecond counter, or a receive bit timed like a sent bit, changes those widths.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
   localparam int BYTE_W   = 8;
   localparam int US_W     = 4;
   localparam int US_SHORT = 3;
   localparam int US_LONG  = 6;

   typedef enum logic [2:0] {
      OP_START = 3'd0,
      OP_STOP  = 3'd1,
      OP_WRITE = 3'd2,
      OP_READ  = 3'd3,
      OP_CLEAR = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      PR_START,
      PR_STOP,
      PR_TX,
      PR_RX
   } prim_e;

   localparam logic [2:0] ERR_NONE     = 3'd0;
   localparam logic [2:0] ERR_SCL_LOW  = 3'd1;
   localparam logic [2:0] ERR_SDA_BIT  = 3'd2;
   localparam logic [2:0] ERR_NACK     = 3'd3;
   localparam logic [2:0] ERR_SDA_STOP = 3'd4;
endpackage

// File: rtl/i2c_bm_sync.sv
module i2c_bm_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_bm_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("i2c_bm_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '1;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '1;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bm_delay.sv
module i2c_bm_delay #(
   parameter int CLKS_PER_US = 4,
   parameter int MAX_US      = 6,
   parameter int US_W        = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [US_W-1:0] us,
   output logic            expired
);
   localparam int CW = $clog2(MAX_US * CLKS_PER_US + 16);

   if (CLKS_PER_US < 1) begin : g_bad_rate
      $error("i2c_bm_delay: CLKS_PER_US must be at least 1");
   end
   if (MAX_US >= (1 << US_W)) begin : g_bad_us
      $error("i2c_bm_delay: MAX_US does not fit in US_W bits");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] ld_val;

   // a step that loads at cycle t is followed by the next step at t + us*CLKS_PER_US
   assign ld_val = CW'(us) * CW'(CLKS_PER_US) - CW'(2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= ld_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/i2c_bm_err.sv
module i2c_bm_err (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic [2:0] code_in,
   output logic [2:0] code_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  code_q <= 3'd0;
      else if (clr)                                code_q <= 3'd0;
      else if (code_q == 3'd0 && code_in != 3'd0)  code_q <= code_in;
   end

   // R9: once set, the code only leaves its value through a clear
   a_r9_first_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q != 3'd0 && !clr) |=> (code_q == $past(code_q)));
endmodule

// File: rtl/i2c_bit_master.sv
module i2c_bit_master
   import i2c_bm_pkg::*;
#(
   parameter int CLKS_PER_US = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [BYTE_W-1:0] cmd_wdata,
   input  logic              cmd_ack,
   output logic              busy,
   output logic              done,
   output logic [BYTE_W-1:0] rd_data,
   output logic              slave_ack,
   output logic [2:0]        err_code,
   output logic              scl_o,
   output logic              sda_o,
   input  logic              scl_i,
   input  logic              sda_i
);
   localparam int STEP_W = 3;
   localparam int BIT_W  = $clog2(BYTE_W + 1);

   if (CLKS_PER_US < 1) begin : g_bad_rate
      $error("i2c_bit_master: CLKS_PER_US must be at least 1");
   end

   typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT, S_FIN} state_e;

   state_e              state_q;
   prim_e               prim_q;
   op_e                 op_q;
   logic [STEP_W-1:0]   step_q;
   logic [BIT_W-1:0]    bits_q;
   logic [BYTE_W-1:0]   shift_q;
   logic                ackv_q, last_q;
   logic                scl_q, sda_q;
   logic [BYTE_W-1:0]   rd_q;
   logic                sack_q, done_q;

   // line read-back
   logic [1:0] line_s;
   logic       scl_s, sda_s;

   i2c_bm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({scl_i, sda_i}),
      .q    (line_s)
   );
   assign scl_s = line_s[1];
   assign sda_s = line_s[0];

   // per-step action decode
   logic            n_scl, n_sda, a_last, a_smp;
   logic            c_scl, c_bit, c_stop, tx_bit;
   logic [US_W-1:0] w_us;

   assign tx_bit = (op_q == OP_WRITE) ? shift_q[BYTE_W-1] : ackv_q;

   always_comb begin
      n_scl  = scl_q;
      n_sda  = sda_q;
      w_us   = US_W'(US_SHORT);
      a_last = 1'b0;
      a_smp  = 1'b0;
      c_scl  = 1'b0;
      c_bit  = 1'b0;
      c_stop = 1'b0;
      unique case (prim_q)
         PR_START: begin
            case (step_q)
               3'd0:    n_sda = 1'b1;
               3'd1:    n_scl = 1'b1;
               3'd2:    begin c_scl = 1'b1; w_us = US_W'(US_LONG); end
               3'd3:    begin n_sda = 1'b0; w_us = US_W'(US_LONG); end
               default: begin n_scl = 1'b0; w_us = US_W'(US_LONG); a_last = 1'b1; end
            endcase
         end
         PR_STOP: begin
            case (step_q)
               3'd0:    n_sda = 1'b0;
               3'd1:    n_scl = 1'b1;
               3'd2:    begin c_scl = 1'b1; w_us = US_W'(US_LONG); end
               3'd3:    n_sda = 1'b1;
               default: begin c_stop = 1'b1; a_last = 1'b1; end
            endcase
         end
         PR_TX: begin
            case (step_q)
               3'd0:    begin n_sda = tx_bit; w_us = tx_bit ? US_W'(US_SHORT) : '0; end
               3'd1:    begin c_bit = tx_bit; w_us = US_W'(US_LONG); end
               3'd2:    n_scl = 1'b1;
               3'd3:    begin c_scl = 1'b1; w_us = US_W'(US_LONG); end
               default: begin n_scl = 1'b0; w_us = US_W'(US_LONG); a_last = 1'b1; end
            endcase
         end
         default: begin
            case (step_q)
               3'd0:    begin n_sda = 1'b1; w_us = US_W'(US_LONG); end
               3'd1:    n_scl = 1'b1;
               3'd2:    c_scl = 1'b1;
               default: begin a_smp = 1'b1; n_scl = 1'b0; w_us = US_W'(US_LONG); a_last = 1'b1; end
            endcase
         end
      endcase
   end

   // error reporting
   logic       in_run;
   logic [2:0] code_sel;
   logic       err_clr, accept;

   assign in_run = (state_q == S_RUN);
   assign accept = (state_q == S_IDLE) && cmd_valid && (cmd_op <= 3'(OP_CLEAR));

   always_comb begin
      code_sel = ERR_NONE;
      if (in_run) begin
         if (c_scl && !scl_s)                             code_sel = ERR_SCL_LOW;
         else if (c_bit && !sda_s)                        code_sel = ERR_SDA_BIT;
         else if (c_stop && !sda_s)                       code_sel = ERR_SDA_STOP;
         else if (a_smp && op_q == OP_WRITE && sda_s)     code_sel = ERR_NACK;
      end
   end

   assign err_clr = accept && (cmd_op == 3'(OP_CLEAR));

   i2c_bm_err u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (err_clr),
      .code_in(code_sel),
      .code_q (err_code)
   );

   // phase timer
   logic dly_load, dly_exp;
   assign dly_load = in_run && (w_us != '0);

   i2c_bm_delay #(.CLKS_PER_US(CLKS_PER_US), .MAX_US(US_LONG), .US_W(US_W)) u_delay (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (dly_load),
      .us     (w_us),
      .expired(dly_exp)
   );

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         prim_q  <= PR_START;
         op_q    <= OP_START;
         step_q  <= '0;
         bits_q  <= '0;
         shift_q <= '0;
         ackv_q  <= 1'b1;
         last_q  <= 1'b0;
         scl_q   <= 1'b1;
         sda_q   <= 1'b1;
         rd_q    <= '0;
         sack_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (accept) begin
                  op_q    <= op_e'(cmd_op);
                  shift_q <= cmd_wdata;
                  ackv_q  <= cmd_ack;
                  bits_q  <= '0;
                  step_q  <= '0;
                  last_q  <= 1'b0;
                  state_q <= S_RUN;
                  case (op_e'(cmd_op))
                     OP_START: prim_q  <= PR_START;
                     OP_STOP:  prim_q  <= PR_STOP;
                     OP_WRITE: prim_q  <= PR_TX;
                     OP_READ:  prim_q  <= PR_RX;
                     default:  state_q <= S_FIN;
                  endcase
               end
            end
            S_FIN: begin
               state_q <= S_IDLE;
               done_q  <= 1'b1;
            end
            S_RUN: begin
               scl_q  <= n_scl;
               sda_q  <= n_sda;
               step_q <= step_q + STEP_W'(1);
               if (a_smp) begin
                  if (op_q == OP_READ) shift_q <= {shift_q[BYTE_W-2:0], sda_s};
                  else                 sack_q  <= sda_s;
               end
               if (w_us != '0) begin
                  last_q  <= a_last;
                  state_q <= S_WAIT;
               end
            end
            default: begin
               if (dly_exp) begin
                  state_q <= S_RUN;
                  if (last_q) begin
                     last_q <= 1'b0;
                     step_q <= '0;
                     case (prim_q)
                        PR_TX: begin
                           if (op_q == OP_WRITE) begin
                              shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
                              bits_q  <= bits_q + BIT_W'(1);
                              if (bits_q == BIT_W'(BYTE_W - 1)) prim_q <= PR_RX;
                           end else begin
                              rd_q    <= shift_q;
                              state_q <= S_IDLE;
                              done_q  <= 1'b1;
                           end
                        end
                        PR_RX: begin
                           if (op_q == OP_READ) begin
                              bits_q <= bits_q + BIT_W'(1);
                              if (bits_q == BIT_W'(BYTE_W - 1)) prim_q <= PR_TX;
                           end else begin
                              state_q <= S_IDLE;
                              done_q  <= 1'b1;
                           end
                        end
                        default: begin
                           state_q <= S_IDLE;
                           done_q  <= 1'b1;
                        end
                     endcase
                  end
               end
            end
         endcase
      end
   end

   assign busy      = (state_q != S_IDLE);
   assign done      = done_q;
   assign rd_data   = rd_q;
   assign slave_ack = sack_q;
   assign scl_o     = scl_q;
   assign sda_o     = sda_q;

   // R10: end-of-command pulse is a single cycle
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: the pulse marks the first idle cycle after a busy stretch
   a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R11: the two line controls never move together
   a_r11_lines_move_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(scl_q) |-> $stable(sda_q));

   // R10: nothing moves on the bus while idle
   a_r10_idle_lines_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!busy) && !busy) |-> ($stable(scl_q) && $stable(sda_q)));
endmodule

// File: tb/tb_i2c_bit_master.sv
module tb_i2c_bit_master;
   localparam int  US       = 2;
   localparam time CLK_PER  = 10ns;
   localparam int  WDOG_CYC = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [7:0] cmd_wdata = 8'h00;
   logic       cmd_ack = 1'b0;
   logic       busy, done, slave_ack, scl_o, sda_o;
   logic [7:0] rd_data;
   logic [2:0] err_code;

   // bus model
   logic       hold_scl = 1'b0, hold_sda = 1'b0, slv_sda = 1'b1;
   logic       scl_line, sda_line;
   assign scl_line = scl_o & ~hold_scl;
   assign sda_line = sda_o & ~hold_sda & slv_sda;

   i2c_bit_master #(.CLKS_PER_US(US)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack), .busy(busy), .done(done),
      .rd_data(rd_data), .slave_ack(slave_ack), .err_code(err_code),
      .scl_o(scl_o), .sda_o(sda_o), .scl_i(scl_line), .sda_i(sda_line)
   );

   always #(CLK_PER/2) clk = ~clk;

   int n_cmp = 0, n_bad = 0;

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   // behavioural slave: mode 0 idle, 1 receive a byte, 2 send a byte
   int         slv_mode = 0, slv_cnt = 0;
   logic       slv_ack_en = 1'b1, slv_mack = 1'b1;
   logic [7:0] slv_tx = 8'h00, slv_cap = 8'h00;

   always @(posedge scl_line) begin
      if (slv_mode == 1 && slv_cnt < 8) slv_cap = {slv_cap[6:0], sda_line};
      if (slv_mode == 2 && slv_cnt == 8) slv_mack = sda_line;
      if (slv_mode != 0) slv_cnt++;
   end

   always @(negedge scl_line) begin
      if (slv_mode == 1) begin
         if (slv_cnt == 8) slv_sda = ~slv_ack_en;
         if (slv_cnt == 9) slv_sda = 1'b1;
      end else if (slv_mode == 2) begin
         if (slv_cnt < 8)  slv_sda = slv_tx[7 - slv_cnt];
         if (slv_cnt == 8) slv_sda = 1'b1;
      end
   end

   task automatic slave_set(input int mode, input logic [7:0] tx, input logic ack_en);
      slv_mode = mode; slv_cnt = 0; slv_tx = tx; slv_ack_en = ack_en;
      slv_sda = (mode == 2) ? tx[7] : 1'b1;
   endtask

   // start / stop condition monitor on the wired lines
   int n_start = 0, n_stop = 0;
   always @(negedge sda_line) if (scl_line === 1'b1) n_start++;
   always @(posedge sda_line) if (scl_line === 1'b1) n_stop++;

   // SCL high-width monitor, in clock cycles
   int hi_cnt = 0;
   int pw_q[$];
   always @(posedge clk) begin
      if (scl_o === 1'b1 && rst_n) hi_cnt++;
      else if (hi_cnt > 0) begin pw_q.push_back(hi_cnt); hi_cnt = 0; end
   end

   // scoreboard
   typedef struct {
      logic       chk_rd;
      logic [7:0] rd;
      logic       chk_ack;
      logic       ack;
      logic [2:0] err;
      string      tag;
   } exp_t;
   exp_t exp_q[$];

   always @(negedge clk) begin
      if (done === 1'b1) begin
         if (exp_q.size() == 0) begin
            check("R10 unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " err_code"}, {29'd0, err_code}, {29'd0, e.err});
            if (e.chk_rd)  check({e.tag, " rd_data"}, {24'd0, rd_data}, {24'd0, e.rd});
            if (e.chk_ack) check({e.tag, " slave_ack"}, {31'd0, slave_ack}, {31'd0, e.ack});
         end
      end
   end

   task automatic run_cmd(input logic [2:0] op, input logic [7:0] wd, input logic ak,
                          input logic crd, input logic [7:0] erd,
                          input logic cak, input logic eak,
                          input logic [2:0] eer, input string tag);
      exp_t e;
      e.chk_rd = crd; e.rd = erd; e.chk_ack = cak; e.ack = eak; e.err = eer; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      cmd_op = op; cmd_wdata = wd; cmd_ack = ak; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check({tag, " R10 busy after accept"}, {31'd0, busy}, 32'd1);
      while (done !== 1'b1) @(negedge clk);
      check({tag, " R10 busy low at done"}, {31'd0, busy}, 32'd0);
      @(negedge clk);
      check({tag, " R10 done single cycle"}, {31'd0, done}, 32'd0);
   endtask

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int s0, p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 scl_o", {31'd0, scl_o}, 32'd1);
      check("R1 sda_o", {31'd0, sda_o}, 32'd1);
      check("R1 busy", {31'd0, busy}, 32'd0);
      check("R1 done", {31'd0, done}, 32'd0);
      check("R1 err_code", {29'd0, err_code}, 32'd0);

      // R2 START
      s0 = n_start;
      run_cmd(3'd0, 8'h00, 1'b0, 0, 8'h00, 0, 0, 3'd0, "R2 start");
      check("R2 one start condition", n_start - s0, 32'd1);
      check("R2 lines low after start", {30'd0, scl_o, sda_o}, 32'd0);

      // R3 + R11 WRITE acknowledged
      slave_set(1, 8'h00, 1'b1);
      pw_q.delete();
      run_cmd(3'd2, 8'hA5, 1'b0, 0, 8'h00, 1, 1'b0, 3'd0, "R3 write A5");
      check("R3 slave captured byte", {24'd0, slv_cap}, 32'h0000_00A5);
      check("R11 pulse count", pw_q.size(), 32'd9);
      for (int i = 0; i < 9 && i < pw_q.size(); i++)
         check($sformatf("R11 SCL high width bit %0d", i), pw_q[i], (i < 8) ? 9 * US : 6 * US);

      // R5 READ with acknowledge
      slave_set(2, 8'h3C, 1'b1);
      run_cmd(3'd3, 8'h00, 1'b0, 1, 8'h3C, 0, 0, 3'd0, "R5 read 3C ack");
      check("R5 master ack level", {31'd0, slv_mack}, 32'd0);

      // R5 READ with no-acknowledge
      slave_set(2, 8'hC3, 1'b1);
      run_cmd(3'd3, 8'h00, 1'b1, 1, 8'hC3, 0, 0, 3'd0, "R5 read C3 nack");
      check("R5 master nack level", {31'd0, slv_mack}, 32'd1);
      slave_set(0, 8'h00, 1'b1);

      // R2 STOP
      p0 = n_stop;
      run_cmd(3'd1, 8'h00, 1'b0, 0, 8'h00, 0, 0, 3'd0, "R2 stop");
      check("R2 one stop condition", n_stop - p0, 32'd1);
      check("R2 lines high after stop", {30'd0, scl_o, sda_o}, 32'd3);

      // R4 NACK on write, then R9 sticky
      run_cmd(3'd0, 8'h00, 1'b0, 0, 8'h00, 0, 0, 3'd0, "R4 start");
      slave_set(1, 8'h00, 1'b0);
      run_cmd(3'd2, 8'h5A, 1'b0, 0, 8'h00, 1, 1'b1, 3'd3, "R4 write nack");
      check("R3 slave captured 5A", {24'd0, slv_cap}, 32'h0000_005A);
      slave_set(1, 8'h00, 1'b1);
      run_cmd(3'd2, 8'h0F, 1'b0, 0, 8'h00, 1, 1'b0, 3'd3, "R9 sticky keeps 3");
      slave_set(0, 8'h00, 1'b1);
      hold_scl = 1'b1;
      run_cmd(3'd0, 8'h00, 1'b0, 0, 8'h00, 0, 0, 3'd3, "R9 later scl fault ignored");
      hold_scl = 1'b0;
      run_cmd(3'd1, 8'h00, 1'b0, 0, 8'h00, 0, 0, 3'd3, "R9 stop");
      run_cmd(3'd4, 8'h00, 1'b0, 0, 8'h00, 0, 0, 3'd0, "R9 clear");

      // R6 SCL held low
      hold_scl = 1'b1;
      run_cmd(3'd0, 8'h00, 1'b0, 0, 8'h00, 0, 0, 3'd1, "R6 scl stuck");
      hold_scl = 1'b0;
      run_cmd(3'd4, 8'h00, 1'b0, 0, 8'h00, 0, 0, 3'd0, "R9 clear after R6");

      // R7 SDA held low while sending a 1
      run_cmd(3'd0, 8'h00, 1'b0, 0, 8'h00, 0, 0, 3'd0, "R7 start");
      hold_sda = 1'b1;
      run_cmd(3'd2, 8'h80, 1'b0, 0, 8'h00, 1, 1'b0, 3'd2, "R7 sda stuck on 1 bit");
      run_cmd(3'd4, 8'h00, 1'b0, 0, 8'h00, 0, 0, 3'd0, "R9 clear after R7");

      // R8 SDA held low at end of STOP
      run_cmd(3'd1, 8'h00, 1'b0, 0, 8'h00, 0, 0, 3'd4, "R8 sda stuck at stop");
      hold_sda = 1'b0;
      repeat (4) @(negedge clk);
      check("R8 code held after release", {29'd0, err_code}, 32'd4);
      check("R10 scoreboard drained", exp_q.size(), 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule